// File: doc/BRIEF.md
# Overlay Window Region and Blend Selector

This block sits in the pixel path of a display controller that stacks five rectangular overlay windows. Each cycle it takes the raster position (x, y) and the colour of the pixel fetched there. It reports which windows cover that position and picks the topmost one. For that window it returns the blend controls: the per-channel constant alpha and the colour-key result. The pixel fetch, the blend arithmetic and the palette lookup are done elsewhere.

Software programs the window rectangles, the enables, the alpha values and the colour-key settings through a single-cycle write port. Each write names a window index, a register code and a 32-bit data word. Window 0 is the background. It has no alpha and no colour key, so its blend outputs are always fully opaque with no keying. All results are registered, and each result appears one clock after its coordinates.

Top module: `ovl_window_select`

## Requirements
- R1: While `rst_n` is low, and after its release until a window is set up, the outputs are `hit_o`=0, `top_valid_o`=0, `top_idx_o`=0, every alpha channel 0xF, and all key flags 0. Every window resets to disabled, with alpha 0xF and its key disabled.
- R2: Window w covers pixel (x, y) when left ≤ x ≤ right and top ≤ y ≤ bottom, with all four bounds inclusive. Register code 0 holds the top-left corner and code 1 holds the bottom-right corner. In both, x is in data bits [CW-1:0] and y is in bits [16+CW-1:16].
- R3: A window is reported in `hit_o` only while its enable bit is set. The enable bit is bit 0 of register code 2.
- R4: `hit_o[w]` is set for every covering window. `top_valid_o` is the OR of `hit_o`, and `top_idx_o` is the highest covering index.
- R5: Each result is registered. The outputs sampled after clock edge n reflect the pixel inputs and the register state that were present just before edge n, and a new pixel can be presented every cycle.
- R6: When window 0 is on top, the alpha outputs are all 0xF and the key flags are 0. Writes to window 0's alpha or key registers (codes 3 to 6) have no effect.
- R7: For a top window 1..4, `alpha_r_o`, `alpha_g_o` and `alpha_b_o` come from register code 3, in data bits [11:8], [7:4] and [3:0] respectively. The value 0xF means opaque.
- R8: Register code 4 holds the key control: bit 0 enables the key, bit 1 enables key blending and bit 2 selects the direction. Code 5 holds the compare mask and code 6 holds the key colour. `key_match_o` is 1 when the top window's key is enabled and (pixel XOR key) AND mask is zero. `key_blend_o` is 1 when both bit 0 and bit 1 are set.
- R9: With the key enabled, `key_transp_o` is 1 on a match when the direction bit is 0, and on a mismatch when the direction bit is 1.
- R10: Writes with a window index of NWIN or greater change no window.
- R11: When no window covers the pixel, `top_valid_o`=0, `top_idx_o`=0, the alpha outputs are all 0xF and the key flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | IW | Window index for the write |
| wr_reg | input | 3 | Register code for the write |
| wr_data | input | 32 | Write data |
| pix_x | input | CW | Current pixel column |
| pix_y | input | CW | Current pixel row |
| pix_color | input | KW | Fetched pixel colour used for the key compare |
| hit_o | output | NWIN | Covering windows, one bit per window |
| top_valid_o | output | 1 | At least one window covers the pixel |
| top_idx_o | output | IW | Index of the topmost covering window |
| alpha_r_o | output | 4 | Red constant alpha of the top window |
| alpha_g_o | output | 4 | Green constant alpha of the top window |
| alpha_b_o | output | 4 | Blue constant alpha of the top window |
| key_match_o | output | 1 | Masked colour key matched |
| key_transp_o | output | 1 | Key makes the pixel transparent |
| key_blend_o | output | 1 | Key blending enabled for the top window |

## Verification
A register write and a pixel lookup can fall in the same cycle. The bench provokes this by enabling a window in the same cycle that it presents a pixel inside that window. It expects the lookup to use the old state and show only the background, and it expects the next identical pixel to show the newly enabled window. Back-to-back pixels that cross a window edge are also checked cycle by cycle, which confirms the single register stage between coordinates and result.

// File: rtl/ovl_window_select.sv
module ovl_window_select #(
  parameter int NWIN = 5,
  parameter int CW   = 12,
  parameter int KW   = 32,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_win,
  input  logic [2:0]      wr_reg,
  input  logic [31:0]     wr_data,
  input  logic [CW-1:0]   pix_x,
  input  logic [CW-1:0]   pix_y,
  input  logic [KW-1:0]   pix_color,
  output logic [NWIN-1:0] hit_o,
  output logic            top_valid_o,
  output logic [IW-1:0]   top_idx_o,
  output logic [3:0]      alpha_r_o,
  output logic [3:0]      alpha_g_o,
  output logic [3:0]      alpha_b_o,
  output logic            key_match_o,
  output logic            key_transp_o,
  output logic            key_blend_o
);
  localparam logic [2:0] RG_TL = 3'd0, RG_BR = 3'd1, RG_CTL = 3'd2, RG_ALPHA = 3'd3,
                         RG_KCTL = 3'd4, RG_KMASK = 3'd5, RG_KVAL = 3'd6;

  logic [CW-1:0]   tl_x [NWIN], tl_y [NWIN], br_x [NWIN], br_y [NWIN];
  logic [11:0]     alpha [NWIN];
  logic [2:0]      kctl  [NWIN];
  logic [KW-1:0]   kmask [NWIN], kval [NWIN];
  logic [NWIN-1:0] en;

  wire win_ok  = wr_en && ({1'b0, wr_win} < (IW+1)'(NWIN));
  wire blend_w = wr_win != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      for (int w = 0; w < NWIN; w++) begin
        tl_x[w]  <= '0;
        tl_y[w]  <= '0;
        br_x[w]  <= '0;
        br_y[w]  <= '0;
        alpha[w] <= 12'hFFF;
        kctl[w]  <= '0;
        kmask[w] <= '0;
        kval[w]  <= '0;
      end
    end else if (win_ok) begin
      case (wr_reg)
        RG_TL:  begin tl_x[wr_win] <= wr_data[CW-1:0]; tl_y[wr_win] <= wr_data[16+CW-1:16]; end
        RG_BR:  begin br_x[wr_win] <= wr_data[CW-1:0]; br_y[wr_win] <= wr_data[16+CW-1:16]; end
        RG_CTL: en[wr_win] <= wr_data[0];
        RG_ALPHA: if (blend_w) alpha[wr_win] <= wr_data[11:0];
        RG_KCTL:  if (blend_w) kctl[wr_win]  <= wr_data[2:0];
        RG_KMASK: if (blend_w) kmask[wr_win] <= wr_data[KW-1:0];
        RG_KVAL:  if (blend_w) kval[wr_win]  <= wr_data[KW-1:0];
        default: ;
      endcase
    end
  end

  logic [NWIN-1:0] hit_c;
  for (genvar w = 0; w < NWIN; w++) begin : g_hit
    assign hit_c[w] = en[w] && (pix_x >= tl_x[w]) && (pix_x <= br_x[w])
                            && (pix_y >= tl_y[w]) && (pix_y <= br_y[w]);
  end

  logic [IW-1:0] top_c;
  always_comb begin
    top_c = '0;
    for (int w = 0; w < NWIN; w++)
      if (hit_c[w]) top_c = IW'(w);
  end

  wire any_c   = |hit_c;
  wire front_c = any_c && (top_c != '0);
  wire keyed_c = front_c && kctl[top_c][0];
  wire raw_eq  = ((pix_color ^ kval[top_c]) & kmask[top_c]) == '0;
  wire match_c = keyed_c && raw_eq;
  wire trans_c = keyed_c && (kctl[top_c][2] ? !raw_eq : raw_eq);
  wire blend_c = keyed_c && kctl[top_c][1];
  wire [11:0] alpha_c = front_c ? alpha[top_c] : 12'hFFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o        <= '0;
      top_valid_o  <= 1'b0;
      top_idx_o    <= '0;
      {alpha_r_o, alpha_g_o, alpha_b_o} <= 12'hFFF;
      key_match_o  <= 1'b0;
      key_transp_o <= 1'b0;
      key_blend_o  <= 1'b0;
    end else begin
      hit_o        <= hit_c;
      top_valid_o  <= any_c;
      top_idx_o    <= top_c;
      {alpha_r_o, alpha_g_o, alpha_b_o} <= alpha_c;
      key_match_o  <= match_c;
      key_transp_o <= trans_c;
      key_blend_o  <= blend_c;
    end
  end
endmodule

module ovl_window_select_chk #(
  parameter int NWIN = 5,
  parameter int IW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NWIN-1:0] en,
  input logic [NWIN-1:0] hit_o,
  input logic            top_valid_o,
  input logic [IW-1:0]   top_idx_o,
  input logic [3:0]      alpha_r_o,
  input logic [3:0]      alpha_g_o,
  input logic [3:0]      alpha_b_o,
  input logic            key_match_o,
  input logic            key_transp_o,
  input logic            key_blend_o
);
  wire quiet = ({alpha_r_o, alpha_g_o, alpha_b_o} == 12'hFFF) && !key_match_o
               && !key_transp_o && !key_blend_o;

  AST_VALID_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid_o == (|hit_o)); // R4
  AST_TOP_IS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid_o |-> hit_o[top_idx_o]); // R4
  AST_TOP_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid_o |-> ((hit_o >> top_idx_o) == NWIN'(1))); // R4
  AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o & ~$past(en)) == '0); // R3
  AST_BG_OPAQUE: assert property (@(posedge clk) disable iff (!rst_n)
    (top_valid_o && top_idx_o == '0) |-> quiet); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !top_valid_o |-> (top_idx_o == '0 && quiet)); // R11
  AST_TRANSP_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    (key_match_o || key_transp_o || key_blend_o) |-> (top_valid_o && top_idx_o != '0)); // R8
endmodule

bind ovl_window_select ovl_window_select_chk #(.NWIN(NWIN), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .hit_o(hit_o), .top_valid_o(top_valid_o),
  .top_idx_o(top_idx_o), .alpha_r_o(alpha_r_o), .alpha_g_o(alpha_g_o),
  .alpha_b_o(alpha_b_o), .key_match_o(key_match_o), .key_transp_o(key_transp_o),
  .key_blend_o(key_blend_o)
);

// File: tb/tb_ovl_window_select.sv
`timescale 1ns/1ps
module tb_ovl_window_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_win = '0;
  logic [2:0]  wr_reg = '0;
  logic [31:0] wr_data = '0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic [31:0] pix_color = '0;
  logic [4:0]  hit_o;
  logic        top_valid_o;
  logic [2:0]  top_idx_o;
  logic [3:0]  alpha_r_o, alpha_g_o, alpha_b_o;
  logic        key_match_o, key_transp_o, key_blend_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ovl_window_select dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_reg(wr_reg),
    .wr_data(wr_data), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
    .hit_o(hit_o), .top_valid_o(top_valid_o), .top_idx_o(top_idx_o),
    .alpha_r_o(alpha_r_o), .alpha_g_o(alpha_g_o), .alpha_b_o(alpha_b_o),
    .key_match_o(key_match_o), .key_transp_o(key_transp_o), .key_blend_o(key_blend_o)
  );

  task automatic chk(string req, logic [4:0] eh, logic ev, logic [2:0] ei,
                     logic [11:0] ea, logic em, logic et, logic eb);
    logic [23:0] act, exp;
    act = {hit_o, top_valid_o, top_idx_o, alpha_r_o, alpha_g_o, alpha_b_o,
           key_match_o, key_transp_o, key_blend_o};
    exp = {eh, ev, ei, ea, em, et, eb};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] w, logic [2:0] r, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = w; wr_reg = r; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic px(logic [11:0] x, logic [11:0] y, logic [31:0] c);
    @(negedge clk);
    pix_x = x; pix_y = y; pix_color = c;
    @(negedge clk);
  endtask

  function automatic logic [31:0] xy(int x, int y);
    return {4'd0, 12'(y), 4'd0, 12'(x)};
  endfunction

  task automatic t_reset;
    @(negedge clk);
    chk("R1 in reset", 5'b0, 0, 0, 12'hFFF, 0, 0, 0);
    rst_n = 1'b1;
    px(12'd0, 12'd0, 32'h0);
    chk("R1 after reset", 5'b0, 0, 0, 12'hFFF, 0, 0, 0);
  endtask

  task automatic t_setup_geometry;
    wr(0, 0, xy(0, 0));   wr(0, 1, xy(99, 99));  wr(0, 2, 1);
    wr(1, 0, xy(10, 10)); wr(1, 1, xy(19, 19));  wr(1, 3, 32'h359); wr(1, 2, 1);
    wr(3, 0, xy(15, 15)); wr(3, 1, xy(30, 30));  wr(3, 3, 32'h777); wr(3, 2, 1);
    px(5, 5, 0);    chk("R2 R6 background", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0);
    px(10, 10, 0);  chk("R2 R7 top-left corner", 5'b00011, 1, 1, 12'h359, 0, 0, 0);
    px(19, 19, 0);  chk("R4 overlap", 5'b01011, 1, 3, 12'h777, 0, 0, 0);
    px(20, 19, 0);  chk("R2 past right edge", 5'b01001, 1, 3, 12'h777, 0, 0, 0);
    px(9, 10, 0);   chk("R2 left of edge", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0);
    px(30, 30, 0);  chk("R2 bottom-right inclusive", 5'b01001, 1, 3, 12'h777, 0, 0, 0);
    px(31, 15, 0);  chk("R2 beyond right", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0);
    px(100, 5, 0);  chk("R11 no cover", 5'b00000, 0, 0, 12'hFFF, 0, 0, 0);
  endtask

  task automatic t_enable;
    wr(3, 2, 0);
    px(19, 19, 0);  chk("R3 disabled window", 5'b00011, 1, 1, 12'h359, 0, 0, 0);
  endtask

  task automatic t_stream;
    @(negedge clk); pix_x = 9;  pix_y = 10;
    @(negedge clk); chk("R5 stream x=9", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0); pix_x = 10;
    @(negedge clk); chk("R5 stream x=10", 5'b00011, 1, 1, 12'h359, 0, 0, 0); pix_x = 20;
    @(negedge clk); chk("R5 stream x=20", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0);
  endtask

  task automatic t_win0_ignored;
    wr(0, 3, 32'h123); wr(0, 4, 32'h7); wr(0, 5, 32'h0);
    px(5, 5, 32'h55);
    chk("R6 win0 writes ignored", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0);
  endtask

  task automatic t_key;
    wr(1, 4, 32'h3); wr(1, 5, 32'h00FF00FF); wr(1, 6, 32'h00120034);
    px(12, 12, 32'hAB12CD34); chk("R8 R9 match dir0", 5'b00011, 1, 1, 12'h359, 1, 1, 1);
    px(12, 12, 32'h00120035); chk("R8 R9 miss dir0", 5'b00011, 1, 1, 12'h359, 0, 0, 1);
    wr(1, 4, 32'h5);
    px(12, 12, 32'hAB12CD34); chk("R9 match dir1", 5'b00011, 1, 1, 12'h359, 1, 0, 0);
    px(12, 12, 32'h00130034); chk("R9 miss dir1", 5'b00011, 1, 1, 12'h359, 0, 1, 0);
    wr(1, 4, 32'h0);
    px(12, 12, 32'hAB12CD34); chk("R8 key off", 5'b00011, 1, 1, 12'h359, 0, 0, 0);
  endtask

  task automatic t_bad_index;
    wr(5, 2, 0); wr(7, 2, 0); wr(5, 3, 32'h000);
    px(12, 12, 0);
    chk("R10 index out of range", 5'b00011, 1, 1, 12'h359, 0, 0, 0);
  endtask

  task automatic t_same_cycle;
    wr(2, 0, xy(40, 40)); wr(2, 1, xy(49, 49));
    @(negedge clk);
    wr_en = 1'b1; wr_win = 2; wr_reg = 2; wr_data = 1;
    pix_x = 45; pix_y = 45; pix_color = 0;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R5 write same cycle uses old state", 5'b00001, 1, 0, 12'hFFF, 0, 0, 0);
    @(negedge clk);
    chk("R3 R5 write visible next cycle", 5'b00101, 1, 2, 12'hFFF, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_setup_geometry();
    t_enable();
    t_stream();
    t_win0_ignored();
    t_key();
    t_bad_index();
    t_same_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule